// File: doc/BRIEF.md
# Tighten-only sector protection register

This block holds the protection setting for a data-flash array and decides, for every program or erase request, whether the target sector may be touched. The setting is one byte. Bit 7 is a "protection open" flag. Bits 3:0 are a size field that counts protected sectors from the bottom of the array. Bits 6:4 carry nothing.

Out of reset the block fetches its starting value from a fixed configuration address in non-volatile memory, using a request/acknowledge handshake. It reports busy until that fetch completes. If the fetch returns a double-bit fault, the block falls back to the tightest setting and raises a fault flag that stays set until the next reset.

Once the block is loaded, software writes pass through a filter that only ever tightens protection. The open flag may only go from 1 to 0. The size field may only grow. Each of the two parts is judged on its own.

Access requests are answered one cycle later. Each request is either passed on through a forward strobe or refused with a violation pulse.

Top module: `flash_guard_reg`

## Requirements
- R1: While reset is held and right after it is released, busy is 1, cfg_req is 1, cfg_addr equals the BOOT_ADDR parameter, bus_rdata reads 8'h0F, fault_sticky is 0, and acc_fwd and violation are 0.
- R2: At the first clock edge where cfg_ack is 1 and cfg_dbl_fault is 0, bus_rdata takes cfg_data with bits 6:4 forced to 0. From that edge on, busy and cfg_req are 0 until the next reset.
- R3: If cfg_dbl_fault is 1 at the acknowledging edge, bus_rdata becomes 8'h0F (open bit 0, size 4'hF) and fault_sticky becomes 1. fault_sticky then stays 1 until reset.
- R4: A bus write made while busy is 1 leaves bus_rdata unchanged.
- R5: A write can clear the open bit (bit 7) from 1 to 0. A write of 1 to that bit while it reads 0 leaves it 0.
- R6: A write changes the size field (bits 3:0) only when the written value is strictly greater than the current value. A smaller or equal value leaves the field unchanged.
- R7: Within one write, the open bit and the size field are filtered separately, so a write that is legal for one part updates that part alone.
- R8: bus_rdata bits 6:4 always read 0, whatever value is written or loaded.
- R9: While the open bit is 1 and busy is 0, every request is forwarded: acc_fwd is 1 in the cycle after acc_req, and violation stays 0.
- R10: While the open bit is 0, a request to a sector index less than or equal to the size field gives violation=1 and acc_fwd=0 in the next cycle. A request to a higher index gives acc_fwd=1 and violation=0. Each pulse lasts one cycle, and without a request both outputs are 0.
- R11: A request made while busy is 1 is refused: violation=1 and acc_fwd=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_req | output | 1 | Configuration byte fetch request |
| cfg_addr | output | ADDR_W | Fixed address of the configuration byte |
| cfg_ack | input | 1 | Fetch complete; cfg_data and cfg_dbl_fault are valid |
| cfg_data | input | 8 | Configuration byte |
| cfg_dbl_fault | input | 1 | Uncorrectable error on the fetched byte |
| busy | output | 1 | Start-up load not finished |
| fault_sticky | output | 1 | Start-up load hit a double-bit fault |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Protection setting in force |
| acc_req | input | 1 | Program or erase request |
| acc_sector | input | SECTOR_W | Sector index of the request |
| acc_fwd | output | 1 | Request allowed and passed on (next cycle) |
| violation | output | 1 | Request refused (next cycle, one cycle pulse) |

## Verification
A wrong internal setting is visible on bus_rdata in the cycle right after the write or load that produced it, because readback has no extra register stage. A loosened setting also shows one cycle after any request to the affected sector, as a forward where a violation was due. The bench therefore reads the register after every write and probes sectors on both sides of the size boundary, so a filter that lets through an equal, smaller or reopening value is caught in the next cycle. A boot sequencer that releases busy too early or mishandles a fault shows up in the same cycle as the acknowledge.

// File: rtl/fgr_pkg.sv
package fgr_pkg;
   localparam int REG_W   = 8;
   localparam int SIZE_W  = 4;
   localparam int OPEN_IX = 7;

   typedef struct packed {
      logic              open;
      logic [SIZE_W-1:0] size;
   } prot_t;

   localparam prot_t FAILSAFE = '{open: 1'b0, size: {SIZE_W{1'b1}}};

   function automatic logic [REG_W-1:0] to_byte(prot_t p);
      logic [REG_W-1:0] b;
      b              = '0;
      b[OPEN_IX]     = p.open;
      b[SIZE_W-1:0]  = p.size;
      return b;
   endfunction

   function automatic prot_t from_byte(logic [REG_W-1:0] b);
      prot_t p;
      p.open = b[OPEN_IX];
      p.size = b[SIZE_W-1:0];
      return p;
   endfunction
endpackage

// File: rtl/fgr_boot_load.sv
module fgr_boot_load
   import fgr_pkg::*;
#(
   parameter int                ADDR_W    = 18,
   parameter logic [ADDR_W-1:0] BOOT_ADDR = 18'h3FF0D
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cfg_req,
   output logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_ack,
   input  logic [REG_W-1:0]  cfg_data,
   input  logic              cfg_dbl_fault,
   output logic              busy,
   output logic              load_en,
   output prot_t             load_val,
   output logic              fault_sticky
);
   typedef enum logic {BL_FETCH, BL_DONE} bl_state_e;
   bl_state_e state_q;

   assign busy     = (state_q == BL_FETCH);
   assign cfg_req  = busy;
   assign cfg_addr = BOOT_ADDR;
   assign load_en  = busy && cfg_ack;
   assign load_val = cfg_dbl_fault ? FAILSAFE : from_byte(cfg_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= BL_FETCH;
         fault_sticky <= 1'b0;
      end else if (load_en) begin
         state_q      <= BL_DONE;
         fault_sticky <= cfg_dbl_fault;
      end
   end
endmodule

// File: rtl/fgr_write_filter.sv
module fgr_write_filter
   import fgr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  prot_t            load_val,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output prot_t            cur
);
   prot_t wr_val, nxt;

   always_comb begin
      wr_val      = from_byte(wdata);
      nxt         = cur;
      nxt.open    = cur.open & wr_val.open;
      if (wr_val.size > cur.size)
         nxt.size = wr_val.size;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= FAILSAFE;
      else if (load_en)
         cur <= load_val;
      else if (wr_en)
         cur <= nxt;
   end
endmodule

// File: rtl/fgr_access_check.sv
module fgr_access_check
   import fgr_pkg::*;
#(
   parameter int SECTOR_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                busy,
   input  prot_t               cur,
   input  logic                acc_req,
   input  logic [SECTOR_W-1:0] acc_sector,
   output logic                acc_fwd,
   output logic                violation
);
   logic in_range, blocked;

   generate
      if (SECTOR_W == SIZE_W) begin : g_same_w
         assign in_range = (acc_sector <= cur.size);
      end else begin : g_wide
         assign in_range = (acc_sector[SECTOR_W-1:SIZE_W] == '0) &&
                           (acc_sector[SIZE_W-1:0] <= cur.size);
      end
   endgenerate

   assign blocked = busy || (!cur.open && in_range);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_fwd   <= 1'b0;
         violation <= 1'b0;
      end else begin
         acc_fwd   <= acc_req && !blocked;
         violation <= acc_req && blocked;
      end
   end
endmodule

// File: rtl/flash_guard_reg.sv
module flash_guard_reg
   import fgr_pkg::*;
#(
   parameter int                ADDR_W    = 18,
   parameter logic [ADDR_W-1:0] BOOT_ADDR = 18'h3FF0D,
   parameter int                SECTOR_W  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                cfg_req,
   output logic [ADDR_W-1:0]   cfg_addr,
   input  logic                cfg_ack,
   input  logic [7:0]          cfg_data,
   input  logic                cfg_dbl_fault,
   output logic                busy,
   output logic                fault_sticky,
   input  logic                bus_wr,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   input  logic                acc_req,
   input  logic [SECTOR_W-1:0] acc_sector,
   output logic                acc_fwd,
   output logic                violation
);
   if (SECTOR_W < SIZE_W) begin : g_chk_sector
      $error("SECTOR_W must be at least the size field width");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("ADDR_W must be positive");
   end

   logic  load_en;
   prot_t load_val, cur;

   fgr_boot_load #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)) u_boot (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_req      (cfg_req),
      .cfg_addr     (cfg_addr),
      .cfg_ack      (cfg_ack),
      .cfg_data     (cfg_data),
      .cfg_dbl_fault(cfg_dbl_fault),
      .busy         (busy),
      .load_en      (load_en),
      .load_val     (load_val),
      .fault_sticky (fault_sticky)
   );

   fgr_write_filter u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .load_val(load_val),
      .wr_en   (bus_wr && !busy),
      .wdata   (bus_wdata),
      .cur     (cur)
   );

   fgr_access_check #(.SECTOR_W(SECTOR_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .cur       (cur),
      .acc_req   (acc_req),
      .acc_sector(acc_sector),
      .acc_fwd   (acc_fwd),
      .violation (violation)
   );

   assign bus_rdata = to_byte(cur);
endmodule

// File: rtl/fgr_checker.sv
module fgr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       fault_sticky,
   input logic [7:0] bus_rdata,
   input logic       acc_req,
   input logic       acc_fwd,
   input logic       violation
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[6:4] == 3'b000); // R8
   AST_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !bus_rdata[7] |=> !bus_rdata[7]); // R5
   AST_SIZE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> bus_rdata[3:0] >= $past(bus_rdata[3:0])); // R6
   AST_BUSY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy); // R2
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fault_sticky |=> fault_sticky); // R3
   AST_FWD_XOR_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_fwd && violation)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> !acc_fwd && !violation); // R10
   AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      busy && acc_req |=> violation); // R11
   AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && bus_rdata[7] && acc_req |=> acc_fwd); // R9
endmodule

bind flash_guard_reg fgr_checker u_fgr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .fault_sticky(fault_sticky),
   .bus_rdata   (bus_rdata),
   .acc_req     (acc_req),
   .acc_fwd     (acc_fwd),
   .violation   (violation)
);

// File: tb/flash_guard_reg_tb_top.sv
module flash_guard_reg_tb_top;
   localparam int          ADDR_W   = 18;
   localparam logic [17:0] BOOT     = 18'h3FF0D;
   localparam int          SECTOR_W = 6;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cfg_req, cfg_ack = 1'b0, cfg_dbl_fault = 1'b0;
   logic [ADDR_W-1:0]   cfg_addr;
   logic [7:0]          cfg_data = 8'h00;
   logic                busy, fault_sticky;
   logic                bus_wr = 1'b0;
   logic [7:0]          bus_wdata = 8'h00, bus_rdata;
   logic                acc_req = 1'b0;
   logic [SECTOR_W-1:0] acc_sector = '0;
   logic                acc_fwd, violation;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   flash_guard_reg #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT), .SECTOR_W(SECTOR_W)) dut_i (.*);

   // write data, expected readback; starts from 8'h83 after the load
   localparam logic [15:0] VEC [10] = '{
      16'h85_85, // R6 grow, open kept
      16'h84_85, // R6 smaller ignored
      16'h85_85, // R6 equal ignored
      16'hF7_87, // R8 reserved bits dropped
      16'h09_09, // R5 close, R6 grow
      16'h8A_0A, // R5 reopen refused, R7 size taken
      16'h82_0A, // R7 both refused
      16'h0A_0A, // R6 equal
      16'h8F_0F, // R7 size taken alone
      16'h00_0F  // R6 zero ignored
   };

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic do_access(int sec, string req, logic exp_fwd, logic exp_viol);
      @(negedge clk); acc_req = 1'b1; acc_sector = SECTOR_W'(sec);
      @(negedge clk); acc_req = 1'b0;
      chk(req, {acc_fwd, violation}, {exp_fwd, exp_viol});
      @(negedge clk);
      chk({req, " pulse end"}, {acc_fwd, violation}, 0);
   endtask

   task automatic boot(logic [7:0] d, logic flt);
      repeat (3) @(negedge clk);
      cfg_ack = 1'b1; cfg_data = d; cfg_dbl_fault = flt;
      @(negedge clk);
      cfg_ack = 1'b0; cfg_dbl_fault = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", busy, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy, 1);
      chk("R1 cfg_req", cfg_req, 1);
      chk("R1 cfg_addr", cfg_addr, BOOT);
      chk("R1 rdata", bus_rdata, 8'h0F);
      chk("R1 fault", fault_sticky, 0);
      chk("R1 outputs", {acc_fwd, violation}, 0);

      do_write(8'h80);
      chk("R4 write while busy", bus_rdata, 8'h0F);
      do_access(40, "R11 access while busy", 1'b0, 1'b1);

      boot(8'hF3, 1'b0);
      chk("R2 load value", bus_rdata, 8'h83);
      chk("R2 busy low", busy, 0);
      chk("R2 cfg_req low", cfg_req, 0);
      chk("R8 loaded reserved", bus_rdata[6:4], 0);

      do_access(0, "R9 open sector 0", 1'b1, 1'b0);
      do_access(3, "R9 open sector 3", 1'b1, 1'b0);

      foreach (VEC[i]) begin
         do_write(VEC[i][15:8]);
         chk($sformatf("R5/R6/R7 vector %0d", i), bus_rdata, VEC[i][7:0]);
      end

      do_access(0, "R10 sector 0", 1'b0, 1'b1);
      do_access(15, "R10 sector 15", 1'b0, 1'b1);
      do_access(16, "R10 sector 16", 1'b1, 1'b0);
      do_access(63, "R10 sector 63", 1'b1, 1'b0);

      do_reset();
      boot(8'h0A, 1'b0);
      do_access(10, "R10 boundary sector 10", 1'b0, 1'b1);
      do_access(11, "R10 boundary sector 11", 1'b1, 1'b0);

      do_reset();
      boot(8'h80, 1'b1);
      chk("R3 failsafe value", bus_rdata, 8'h0F);
      chk("R3 fault set", fault_sticky, 1);
      chk("R3 busy low", busy, 0);
      do_write(8'h80);
      repeat (4) @(negedge clk);
      chk("R3 fault held", fault_sticky, 1);
      chk("R5 no reopen after fault", bus_rdata, 8'h0F);

      do_reset();
      @(negedge clk);
      chk("R1 fault cleared", fault_sticky, 0);
      boot(8'h81, 1'b0);
      chk("R2 second load", bus_rdata, 8'h81);
      do_write(8'h02);
      chk("R7 close with grow", bus_rdata, 8'h02);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog R1-chain hung actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule